// File: doc/BRIEF.md
# Card Fundamental-Reset Sequencer

This block drives the active-low fundamental reset line of an add-in card slot. It watches an asynchronous power-good input and a reference-clock-stable input. Reset is released only once power has been good for a fixed minimum time, the reference clock has been reported stable without a break for its own minimum time, and the current reset pulse has lasted its minimum width. Whichever of these windows closes last decides the release.

Software, or a nearby controller, can ask for a warm reset without removing power. The request is a one-cycle pulse, and a hold-length input gives the number of cycles to hold. The hold is never shorter than the minimum pulse width. A second request during a hold can lengthen it but never shorten it. Loss of power asserts reset through a gated combinational path, so the state machine and its two-flop synchronizers add no delay to that path. All delays are given in nanoseconds and the clock rate in kHz. They become cycle counts that are rounded up.

The state machine has five states. ST_POWER_OFF moves to ST_WAIT_POWER_STABLE when the synchronized power-good is high. ST_WAIT_POWER_STABLE moves to ST_WAIT_CLOCK_STABLE when its power window is full. ST_WAIT_CLOCK_STABLE moves to ST_RUN when the clock window is full, the hold count is zero and no request is present. ST_RUN moves to ST_WARM_HOLD on a request. ST_WARM_HOLD moves back to ST_WAIT_CLOCK_STABLE when its hold count reaches zero and no request is present. From every state, a low synchronized power-good forces ST_POWER_OFF.

Top module: `perst_sequencer`

## Requirements
- R1: While rst_n is low, and after it is released, the block is in ST_POWER_OFF: perst_n_o=0, reset_active_o=1, link_start_ok_o=0.
- R2: After power_good_i rises, perst_n_o stays low for at least PWR_CYC cycles, where PWR_CYC = ceil(PWR_STABLE_NS*CLK_KHZ/1e6). With the clock already stable, release comes PWR_CYC+5 cycles after the rise.
- R3: perst_n_o is released only after refclk_stable_i has been high without a break for CK_CYC cycles. A low level that reaches the synchronized copy restarts that window from zero. When the clock is the later constraint, release comes CK_CYC+3 cycles after the last rise of refclk_stable_i.
- R4: Every low period of perst_n_o lasts at least MIN_CYC = ceil(MIN_ASSERT_NS*CLK_KHZ/1e6) cycles.
- R5: While power_good_i is low, perst_n_o and link_start_ok_o are low in the same cycle, without waiting for any clock edge or timer.
- R6: A one-cycle warm_req_i in ST_RUN drives perst_n_o low at the next clock edge. The hold lasts max(warm_hold_cyc_i, MIN_CYC) cycles, and release follows two cycles later if the clock is stable, for a low time of hold+2 cycles.
- R7: A warm_req_i that arrives while reset is held sets the remaining hold to the larger of the current remaining count and the new request's length. Release never comes earlier because of it.
- R8: link_start_ok_o is high only while perst_n_o is high and the synchronized refclk_stable_i is high. reset_active_o is always the inverse of perst_n_o.
- R9: Cycle counts round up. For example, 804 ns at 125000 kHz gives 101 cycles, and a warm request shorter than that gives a low time of exactly 103 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| power_good_i | input | 1 | Power rails valid (asynchronous) |
| refclk_stable_i | input | 1 | Reference clock stable (asynchronous) |
| warm_req_i | input | 1 | One-cycle warm-reset request |
| warm_hold_cyc_i | input | HOLD_W | Requested warm hold length in cycles |
| perst_n_o | output | 1 | Active-low fundamental reset to the card |
| reset_active_o | output | 1 | High while the card is held in reset |
| link_start_ok_o | output | 1 | High when link training may begin |

## Verification
A wrong state or count inside the block shows up at perst_n_o as a release that comes too early or too late. Because the timing of every transition is fixed, the cycle-level model catches the error in the first cycle where the release edge moves. A fault in the fast path shows up within the same cycle that power_good_i drops. A fault in the hold logic shows up as a low pulse whose measured length differs from hold+2. A fault in the clock-restart logic shows up as a release fewer than CK_CYC cycles after the reference clock comes back.

// File: rtl/perst_seq_pkg.sv
package perst_seq_pkg;

    typedef enum logic [2:0] {
        ST_POWER_OFF,
        ST_WAIT_POWER_STABLE,
        ST_WAIT_CLOCK_STABLE,
        ST_RUN,
        ST_WARM_HOLD
    } seq_state_e;

    // Round-up conversion of a duration in ns to cycles of a clock in kHz.
    function automatic longint ns_to_cycles(input longint dur_ns, input longint freq_khz);
        return (dur_ns * freq_khz + 64'd999_999) / 64'd1_000_000;
    endfunction

endpackage

// File: rtl/perst_sync2.sv
module perst_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d[b];
                sync_q <= meta_q;
            end
        end
        assign q[b] = sync_q;
    end

endmodule

// File: rtl/perst_window_cnt.sv
// Counts consecutive enabled cycles, saturating at LIMIT; clears when disabled.
module perst_window_cnt #(
    parameter int LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);

    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIM_V);

endmodule

// File: rtl/perst_hold_cnt.sv
// Remaining-hold down counter with load-minimum, load-length and extend-to-max.
module perst_hold_cnt #(
    parameter int W       = 16,
    parameter int MIN_CYC = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_min,
    input  logic         load_len,
    input  logic         extend,
    input  logic [W-1:0] req_len,
    output logic         zero
);

    localparam logic [W-1:0] MIN_V = W'(MIN_CYC);

    logic [W-1:0] cnt_q;
    logic [W-1:0] dec;

    always_comb begin
        dec = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= MIN_V;
        end else if (load_min) begin
            cnt_q <= MIN_V;
        end else if (load_len) begin
            cnt_q <= req_len;
        end else if (extend && (req_len > dec)) begin
            cnt_q <= req_len;
        end else begin
            cnt_q <= dec;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/perst_sequencer.sv
module perst_sequencer
    import perst_seq_pkg::*;
#(
    parameter int CLK_KHZ         = 125_000,
    parameter int PWR_STABLE_NS   = 100_000_000,
    parameter int CLK_STABLE_NS   = 100_000,
    parameter int MIN_ASSERT_NS   = 100_000,
    parameter int HOLD_W          = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_good_i,
    input  logic              refclk_stable_i,
    input  logic              warm_req_i,
    input  logic [HOLD_W-1:0] warm_hold_cyc_i,
    output logic              perst_n_o,
    output logic              reset_active_o,
    output logic              link_start_ok_o
);

    localparam int PWR_CYC = int'(ns_to_cycles(longint'(PWR_STABLE_NS), longint'(CLK_KHZ)));
    localparam int CK_CYC  = int'(ns_to_cycles(longint'(CLK_STABLE_NS), longint'(CLK_KHZ)));
    localparam int MIN_CYC = int'(ns_to_cycles(longint'(MIN_ASSERT_NS), longint'(CLK_KHZ)));
    localparam logic [HOLD_W-1:0] MIN_V = HOLD_W'(MIN_CYC);

    seq_state_e state_q, state_d;

    logic [1:0]        sync_q;
    logic              pg_s, ck_s;
    logic              pwr_done, ck_done, hold_zero;
    logic              hold_min, hold_len, hold_ext;
    logic [HOLD_W-1:0] req_len;
    logic              released;

    perst_sync2 #(.WIDTH(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({refclk_stable_i, power_good_i}),
        .q     (sync_q)
    );
    assign pg_s = sync_q[0];
    assign ck_s = sync_q[1];

    perst_window_cnt #(.LIMIT(PWR_CYC)) pwr_win_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_WAIT_POWER_STABLE),
        .done  (pwr_done)
    );

    perst_window_cnt #(.LIMIT(CK_CYC)) ck_win_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ck_s),
        .done  (ck_done)
    );

    assign req_len = (warm_hold_cyc_i > MIN_V) ? warm_hold_cyc_i : MIN_V;

    perst_hold_cnt #(.W(HOLD_W), .MIN_CYC(MIN_CYC)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_min (hold_min),
        .load_len (hold_len),
        .extend   (hold_ext),
        .req_len  (req_len),
        .zero     (hold_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWER_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and counter controls
    always_comb begin
        state_d  = state_q;
        hold_min = 1'b0;
        hold_len = 1'b0;
        hold_ext = 1'b0;
        if (!pg_s) begin
            state_d  = ST_POWER_OFF;
            hold_min = 1'b1;
        end else begin
            unique case (state_q)
                ST_POWER_OFF: begin
                    hold_min = 1'b1;
                    state_d  = ST_WAIT_POWER_STABLE;
                end
                ST_WAIT_POWER_STABLE: begin
                    hold_ext = warm_req_i;
                    if (pwr_done) begin
                        state_d = ST_WAIT_CLOCK_STABLE;
                    end
                end
                ST_WAIT_CLOCK_STABLE: begin
                    hold_ext = warm_req_i;
                    if (ck_done && hold_zero && !warm_req_i) begin
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (warm_req_i) begin
                        hold_len = 1'b1;
                        state_d  = ST_WARM_HOLD;
                    end
                end
                ST_WARM_HOLD: begin
                    hold_ext = warm_req_i;
                    if (hold_zero && !warm_req_i) begin
                        state_d = ST_WAIT_CLOCK_STABLE;
                    end
                end
                default: begin
                    state_d = ST_POWER_OFF;
                end
            endcase
        end
    end

    // Outputs: raw power-good gates release directly (fast assertion path)
    always_comb begin
        released        = (state_q == ST_RUN) && power_good_i;
        perst_n_o       = released;
        reset_active_o  = !released;
        link_start_ok_o = released && ck_s;
    end

endmodule

// File: rtl/perst_seq_chk.sv
module perst_seq_chk #(
    parameter int PWR_CYC = 1,
    parameter int CK_CYC  = 1,
    parameter int MIN_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic power_good_i,
    input logic refclk_stable_i,
    input logic warm_req_i,
    input logic perst_n_o,
    input logic reset_active_o,
    input logic link_start_ok_o
);

    logic [31:0] pg_hi_cnt, ck_hi_cnt, low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_hi_cnt <= '0;
            ck_hi_cnt <= '0;
            low_cnt   <= '0;
        end else begin
            pg_hi_cnt <= !power_good_i    ? '0 : (pg_hi_cnt != '1 ? pg_hi_cnt + 1 : pg_hi_cnt);
            ck_hi_cnt <= !refclk_stable_i ? '0 : (ck_hi_cnt != '1 ? ck_hi_cnt + 1 : ck_hi_cnt);
            low_cnt   <= perst_n_o        ? '0 : (low_cnt   != '1 ? low_cnt + 1   : low_cnt);
        end
    end

    p_pwr_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> (pg_hi_cnt >= 32'(PWR_CYC)));

    p_clk_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> (ck_hi_cnt >= 32'(CK_CYC)));

    p_min_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> (low_cnt >= 32'(MIN_CYC)));

    p_fast_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good_i |-> (!perst_n_o && !link_start_ok_o));

    p_warm_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_req_i && perst_n_o) |=> !perst_n_o);

    p_link_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_start_ok_o |-> (perst_n_o && !reset_active_o));

endmodule

bind perst_sequencer perst_seq_chk #(
    .PWR_CYC (PWR_CYC),
    .CK_CYC  (CK_CYC),
    .MIN_CYC (MIN_CYC)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .power_good_i    (power_good_i),
    .refclk_stable_i (refclk_stable_i),
    .warm_req_i      (warm_req_i),
    .perst_n_o       (perst_n_o),
    .reset_active_o  (reset_active_o),
    .link_start_ok_o (link_start_ok_o)
);

// File: tb/perst_sequencer_tb_top.sv
module perst_sequencer_tb_top;

    localparam int CLK_KHZ = 125_000;
    localparam int HOLD_W  = 12;
    // Expected cycle counts worked out by hand (rounded up): 2000ns, 400ns, 804ns at 8ns
    localparam int PWR_C = 250;
    localparam int CK_C  = 50;
    localparam int MIN_C = 101;

    localparam int M_OFF = 0, M_WPS = 1, M_WCS = 2, M_RUN = 3, M_WH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg = 1'b0, ck = 1'b0, warm = 1'b0;
    logic [HOLD_W-1:0] hold_in = '0;
    logic perst_n, active, link;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;
    string tag = "R1";

    always #4 clk = ~clk;

    perst_sequencer #(
        .CLK_KHZ       (CLK_KHZ),
        .PWR_STABLE_NS (2000),
        .CLK_STABLE_NS (400),
        .MIN_ASSERT_NS (804),
        .HOLD_W        (HOLD_W)
    ) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .power_good_i    (pg),
        .refclk_stable_i (ck),
        .warm_req_i      (warm),
        .warm_hold_cyc_i (hold_in),
        .perst_n_o       (perst_n),
        .reset_active_o  (active),
        .link_start_ok_o (link)
    );

    // ---------------- behavioural reference model ----------------
    int m_state = M_OFF, m_pwr = 0, m_ck = 0, m_hold = MIN_C;
    bit pg_pipe[$] = '{1'b0, 1'b0};
    bit ck_pipe[$] = '{1'b0, 1'b0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = M_OFF; m_pwr = 0; m_ck = 0; m_hold = MIN_C;
            pg_pipe = '{1'b0, 1'b0};
            ck_pipe = '{1'b0, 1'b0};
        end else begin
            int req, dec, ns, nh, np, nc;
            bit pgs, cks;
            pgs = pg_pipe[1];
            cks = ck_pipe[1];
            req = (int'(hold_in) > MIN_C) ? int'(hold_in) : MIN_C;
            dec = (m_hold > 0) ? m_hold - 1 : 0;
            nc  = !cks ? 0 : ((m_ck < CK_C) ? m_ck + 1 : m_ck);
            np  = (m_state == M_WPS) ? ((m_pwr < PWR_C) ? m_pwr + 1 : m_pwr) : 0;
            ns  = m_state;
            nh  = dec;
            if (!pgs) begin
                ns = M_OFF; nh = MIN_C;
            end else begin
                case (m_state)
                    M_OFF: begin nh = MIN_C; ns = M_WPS; end
                    M_WPS: begin
                        if (warm && req > dec) nh = req;
                        if (m_pwr == PWR_C) ns = M_WCS;
                    end
                    M_WCS: begin
                        if (warm && req > dec) nh = req;
                        if (m_ck == CK_C && m_hold == 0 && !warm) ns = M_RUN;
                    end
                    M_RUN: if (warm) begin nh = req; ns = M_WH; end
                    M_WH: begin
                        if (warm && req > dec) nh = req;
                        if (m_hold == 0 && !warm) ns = M_WCS;
                    end
                    default: ns = M_OFF;
                endcase
            end
            m_state = ns; m_hold = nh; m_pwr = np; m_ck = nc;
            void'(pg_pipe.pop_back()); pg_pipe.push_front(pg);
            void'(ck_pipe.pop_back()); ck_pipe.push_front(ck);
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        #2;
        if (!finished) begin
            bit e_perst, e_link;
            e_perst = (m_state == M_RUN) && pg;
            e_link  = e_perst && ck_pipe[1];
            n_checks++;
            if (perst_n !== e_perst || active !== !e_perst || link !== e_link) begin
                n_fail++;
                $display("FAIL %s cycle-model t=%0t: perst_n/active/link actual %b%b%b expected %b%b%b",
                         tag, $time, perst_n, active, link, e_perst, !e_perst, e_link);
            end
        end
    end

    // low-run tracker
    int low_run = 0, last_low = 0;
    always @(negedge clk) begin
        #1;
        if (!perst_n) low_run++;
        else begin
            if (low_run > 0) last_low = low_run;
            low_run = 0;
        end
    end

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic wait_high(output int k);
        k = 0;
        while (perst_n !== 1'b1 && k < 2000) begin
            @(negedge clk); #3; k++;
        end
    endtask

    task automatic warm_pulse(input int len);
        @(negedge clk); hold_in = HOLD_W'(len); warm = 1'b1;
        @(negedge clk); warm = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int k;
        // R1: reset state
        repeat (3) @(negedge clk);
        #3 check(perst_n == 0 && active == 1 && link == 0, "R1", "reset outputs",
                 {perst_n, active, link}, 3'b010);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #3 check(perst_n == 0, "R1", "power off after reset", perst_n, 0);

        // R3: clock arrives late, release gated by clock window
        tag = "R3";
        @(negedge clk); pg = 1'b1;
        repeat (240) @(negedge clk);
        ck = 1'b1;
        wait_high(k);
        check(k == CK_C + 3, "R3", "release after late clock", k, CK_C + 3);
        repeat (10) @(negedge clk);

        // R5: fast assertion on power loss
        tag = "R5";
        @(negedge clk); pg = 1'b0;
        #2 check(perst_n == 0 && link == 0, "R5", "same-cycle assert on power drop",
                 {perst_n, link}, 0);
        repeat (20) @(negedge clk);

        // R3: clock glitch restarts window
        tag = "R3";
        pg = 1'b1;
        repeat (230) @(negedge clk);
        ck = 1'b0;
        repeat (3) @(negedge clk);
        ck = 1'b1;
        wait_high(k);
        check(k == CK_C + 3, "R3", "window restart after clock drop", k, CK_C + 3);
        repeat (10) @(negedge clk);

        // R2: power-gated release with clock already stable
        tag = "R2";
        @(negedge clk); pg = 1'b0;
        repeat (20) @(negedge clk);
        pg = 1'b1;
        wait_high(k);
        check(k >= PWR_C, "R2", "release not before power window", k, PWR_C);
        check(k == PWR_C + 5, "R2", "exact power-gated release", k, PWR_C + 5);
        repeat (10) @(negedge clk);

        // R6: warm reset with long hold
        tag = "R6";
        warm_pulse(300);
        #3 check(perst_n == 0, "R6", "warm reset asserts", perst_n, 0);
        wait_high(k);
        @(negedge clk); #3;
        check(last_low == 302, "R6", "warm low time", last_low, 302);
        repeat (10) @(negedge clk);

        // R9 / R4: short hold clamps to rounded-up minimum
        tag = "R9";
        warm_pulse(3);
        wait_high(k);
        @(negedge clk); #3;
        check(last_low == MIN_C + 2, "R9", "rounded minimum hold", last_low, MIN_C + 2);
        check(last_low >= MIN_C, "R4", "minimum assertion width", last_low, MIN_C);
        repeat (10) @(negedge clk);

        // R7: extension during hold, shorter request does not shorten
        tag = "R7";
        warm_pulse(150);
        repeat (40) @(negedge clk);
        warm_pulse(20);
        repeat (58) @(negedge clk);
        warm_pulse(150);
        wait_high(k);
        @(negedge clk); #3;
        check(last_low >= 250, "R7", "extended hold length", last_low, 250);
        check(last_low == 254, "R7", "exact extended low time", last_low, 254);
        repeat (10) @(negedge clk);

        // R8: clock drop in run lowers link flag only
        tag = "R8";
        @(negedge clk); ck = 1'b0;
        repeat (4) @(negedge clk);
        #3 check(link == 0 && perst_n == 1 && active == 0, "R8", "link gated by clock",
                 {link, perst_n, active}, 3'b010);
        ck = 1'b1;
        repeat (60) @(negedge clk);
        #3 check(link == 1, "R8", "link back after clock", link, 1);

        finish_run();
    end

endmodule